// File: doc/BRIEF.md
# Store Buffer with Read-Miss Forwarding

This block holds a short queue of stores between a processor's data cache and the next memory level. A store whose queue slot is free is taken in the same cycle it is offered, so the processor does not stall. Queued stores are written to a single shared memory port one at a time, oldest first.

A read miss is captured and its address is compared with every occupied slot at once. If a slot holds that address, the newest such slot's data is returned and memory is not accessed. If no slot holds it, the read is issued to memory ahead of any store still waiting. A mode input selects a simpler and more conservative policy. In that mode a read miss is held until the queue has drained completely, and it is always answered from memory.

Top module: `store_fwd_buffer`

## Requirements
- R1: While fewer than DEPTH entries are held, `st_ready` is high and an offered store is accepted on the next clock edge with no wait cycle.
- R2: `buf_full` is high and `st_ready` is low exactly when DEPTH entries are held. `buf_empty` is high exactly when none are held.
- R3: When a store is accepted and a drain write completes on the same edge, the number of held entries does not change.
- R4: Entries leave in acceptance order, one per memory handshake (`mem_valid` and `mem_ready` high, `mem_write`=1), carrying the stored address and data.
- R5: With `cfg_wait_empty`=0, a read whose address equals that of a held entry is answered from the buffer (`rsp_from_buf`=1) and issues no memory read.
- R6: When several held entries share the read address, the data of the most recently accepted one is returned.
- R7: With `cfg_wait_empty`=0, a read that matches no held entry is issued to memory (`mem_write`=0) before any further queued write, and its answer has `rsp_from_buf`=0.
- R8: With `cfg_wait_empty`=1, no memory read is issued while any entry is held. The read is issued after the queue empties and is answered from memory with `rsp_from_buf`=0.
- R9: After synchronous reset the queue is empty, `st_ready` is high, and `rsp_valid` and `mem_valid` are low.
- R10: `rsp_valid` is a single-cycle pulse per accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait_empty | input | 1 | 1: reads wait for an empty queue; 0: reads bypass and forward |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read miss can be accepted |
| rd_addr | input | AW | Read miss address |
| rsp_valid | output | 1 | Read answer pulse |
| rsp_data | output | DW | Read answer data |
| rsp_from_buf | output | 1 | Answer came from a held entry |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1: write (drain), 0: read |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| buf_full | output | 1 | All entries held |
| buf_empty | output | 1 | No entries held |

## Verification
The hardest situations to reach are a queue that stays occupied while reads arrive, and the exact cycle in which the read overtakes pending writes. The bench's memory model accepts read requests at once but accepts write requests only while a bench-controlled permission is set. This keeps entries parked, so the bench can choose when the queue fills and which addresses are duplicated. Permission and a read are then raised together, so exactly one write leaves in the accept cycle. The bench then checks that the read reached memory after that write and before the second one. Occupancy after a simultaneous store and drain is measured by counting how many further stores fit before `st_ready` falls.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_CHECK = 2'd1,
    RS_MREQ  = 2'd2,
    RS_MWAIT = 2'd3
  } rd_state_e;
endpackage

// File: rtl/sb_entries.sv
module sb_entries #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [AW-1:0]               push_addr,
  input  logic [DW-1:0]               push_data,
  input  logic                        pop,
  input  logic [PW-1:0]               fwd_idx,
  output logic [DEPTH-1:0]            vld_o,
  output logic [DEPTH-1:0][AW-1:0]    addr_o,
  output logic [PW-1:0]               head_o,
  output logic [AW-1:0]               head_addr,
  output logic [DW-1:0]               head_data,
  output logic [DW-1:0]               fwd_data,
  output logic                        full_o,
  output logic                        empty_o
);
  logic [PW-1:0]            head_q, tail_q;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [DEPTH-1:0]         vld_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DW-1:0]            data_mem [DEPTH];
  logic                     full_q, empty_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // data payload: write-only port plus read taps, no reset (RAM-friendly)
  always_ff @(posedge clk) begin
    if (push) data_mem[tail_q] <= push_data;
  end

  // per-slot tag and valid registers
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[i]  <= 1'b0;
        addr_q[i] <= '0;
      end else if (push && tail_q == PW'(i)) begin
        vld_q[i]  <= 1'b1;
        addr_q[i] <= push_addr;
      end else if (pop && head_q == PW'(i)) begin
        vld_q[i]  <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (push) tail_q <= bump(tail_q);
      if (pop)  head_q <= bump(head_q);
      cnt_q   <= cnt_d;
      full_q  <= (cnt_d == CW'(DEPTH));
      empty_q <= (cnt_d == '0);
    end
  end

  assign vld_o     = vld_q;
  assign addr_o    = addr_q;
  assign head_o    = head_q;
  assign head_addr = addr_q[head_q];
  assign head_data = data_mem[head_q];
  assign fwd_data  = data_mem[fwd_idx];
  assign full_o    = full_q;
  assign empty_o   = empty_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R3
  occupancy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(cnt_q));
  // R2
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    empty_q |-> (vld_q == '0));
  // R2
  full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (&vld_q));
endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][AW-1:0] addr,
  input  logic [PW-1:0]            head,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [PW-1:0]            idx
);
  logic [DEPTH-1:0] eq;

  // one comparator per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = vld[i] && (addr[i] == look_addr);
  end

  // walk slots oldest to youngest; the last match seen is the youngest
  always_comb begin
    int slot;
    hit = 1'b0;
    idx = head;
    for (int k = 0; k < DEPTH; k++) begin
      slot = (int'(head) + k) % DEPTH;
      if (eq[PW'(slot)]) begin
        hit = 1'b1;
        idx = PW'(slot);
      end
    end
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wait_empty,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic [AW-1:0] look_addr,
  input  logic          hit,
  input  logic [DW-1:0] fwd_data,
  input  logic          buf_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          pop,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_from_buf
);
  rd_state_e     state_q, state_d;
  logic [AW-1:0] raddr_q;
  logic          drain_ok;
  logic          rsp_set, rsp_buf_d;
  logic [DW-1:0] rsp_data_d;

  // a waiting read blocks draining, except in wait-for-empty mode
  assign drain_ok  = (state_q == RS_IDLE) ||
                     (state_q == RS_CHECK && cfg_wait_empty);
  assign mem_valid = (state_q == RS_MREQ) || (drain_ok && !buf_empty);
  assign mem_write = (state_q != RS_MREQ);
  assign mem_addr  = (state_q == RS_MREQ) ? raddr_q : head_addr;
  assign mem_wdata = head_data;
  assign pop       = drain_ok && !buf_empty && mem_ready;
  assign rd_ready  = (state_q == RS_IDLE);
  assign look_addr = raddr_q;

  always_comb begin
    state_d    = state_q;
    rsp_set    = 1'b0;
    rsp_buf_d  = 1'b0;
    rsp_data_d = mem_rdata;
    unique case (state_q)
      RS_IDLE:  if (rd_valid) state_d = RS_CHECK;
      RS_CHECK: begin
        if (cfg_wait_empty) begin
          if (buf_empty) state_d = RS_MREQ;
        end else if (hit) begin
          state_d    = RS_IDLE;
          rsp_set    = 1'b1;
          rsp_buf_d  = 1'b1;
          rsp_data_d = fwd_data;
        end else begin
          state_d = RS_MREQ;
        end
      end
      RS_MREQ:  if (mem_ready) state_d = RS_MWAIT;
      RS_MWAIT: if (mem_rvalid) begin
        state_d = RS_IDLE;
        rsp_set = 1'b1;
      end
      default:  state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= RS_IDLE;
      raddr_q      <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_from_buf <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_set;
      if (state_q == RS_IDLE && rd_valid) raddr_q <= rd_addr;
      if (rsp_set) begin
        rsp_data     <= rsp_data_d;
        rsp_from_buf <= rsp_buf_d;
      end
    end
  end

  // R7
  bypass_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_CHECK && !cfg_wait_empty && !hit) |=> (mem_valid && !mem_write));
  // R5
  fwd_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_CHECK && !cfg_wait_empty && hit) |=> (rsp_valid && rsp_from_buf));
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_CHECK && cfg_wait_empty && !buf_empty && $stable(cfg_wait_empty))
      |=> !(mem_valid && !mem_write));
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R7
  read_no_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_write) |-> !pop);
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wait_empty,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_from_buf,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          buf_full,
  output logic          buf_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                     push, pop, hit;
  logic [PW-1:0]            fwd_idx, head;
  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [AW-1:0]            head_addr, look_addr;
  logic [DW-1:0]            head_data, fwd_data;

  assign st_ready = !buf_full;
  assign push     = st_valid && st_ready;

  sb_entries #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_entries (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (pop),
    .fwd_idx   (fwd_idx),
    .vld_o     (vld),
    .addr_o    (slot_addr),
    .head_o    (head),
    .head_addr (head_addr),
    .head_data (head_data),
    .fwd_data  (fwd_data),
    .full_o    (buf_full),
    .empty_o   (buf_empty)
  );

  sb_match #(.AW(AW), .DEPTH(DEPTH)) u_match (
    .vld       (vld),
    .addr      (slot_addr),
    .head      (head),
    .look_addr (look_addr),
    .hit       (hit),
    .idx       (fwd_idx)
  );

  sb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .cfg_wait_empty (cfg_wait_empty),
    .rd_valid       (rd_valid),
    .rd_addr        (rd_addr),
    .rd_ready       (rd_ready),
    .look_addr      (look_addr),
    .hit            (hit),
    .fwd_data       (fwd_data),
    .buf_empty      (buf_empty),
    .head_addr      (head_addr),
    .head_data      (head_data),
    .pop            (pop),
    .mem_valid      (mem_valid),
    .mem_write      (mem_write),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ready      (mem_ready),
    .mem_rvalid     (mem_rvalid),
    .mem_rdata      (mem_rdata),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .rsp_from_buf   (rsp_from_buf)
  );

  // R5
  fwd_slot_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (vld[fwd_idx] && slot_addr[fwd_idx] == look_addr));
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !buf_full) |=> !buf_empty);
  // R4
  drain_head_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write) |-> vld[head]);
endmodule

// File: tb/store_fwd_buffer_bench.sv
module store_fwd_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wait_empty = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        st_ready, rd_ready, rsp_valid, rsp_from_buf;
  logic [31:0] rsp_data;
  logic        mem_valid, mem_ready, mem_write, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        buf_full, buf_empty;
  logic        drain_allow = 1'b0;

  int nchk = 0, nfail = 0;
  int wcount = 0, rcount = 0, rd_pos = 0;
  logic [31:0] bmem [16];
  logic [31:0] wlog_a [32];
  logic [31:0] wlog_d [32];

  always #5 clk = ~clk;

  store_fwd_buffer u_store_fwd_buffer (
    .clk(clk), .rst(rst), .cfg_wait_empty(cfg_wait_empty),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_from_buf(rsp_from_buf),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .buf_full(buf_full), .buf_empty(buf_empty)
  );

  // memory model: reads always accepted, writes only while permitted
  assign mem_ready = mem_valid && (!mem_write || drain_allow);

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 32'hA000_0000 + i;
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        bmem[mem_addr[5:2]] <= mem_wdata;
        wlog_a[wcount % 32] <= mem_addr;
        wlog_d[wcount % 32] <= mem_wdata;
        wcount <= wcount + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= bmem[mem_addr[5:2]];
        rd_pos     <= wcount;
        rcount     <= rcount + 1;
      end
    end
  end

  typedef struct packed {
    logic        is_rd;
    logic        exp_buf;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  // stores: data is written; reads: data is the expected answer
  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 32'h10, 32'h1111_0001},
    '{1'b0, 1'b0, 32'h20, 32'h2222_0002},
    '{1'b1, 1'b1, 32'h10, 32'h1111_0001},  // R5
    '{1'b0, 1'b0, 32'h10, 32'h3333_0003},
    '{1'b1, 1'b1, 32'h10, 32'h3333_0003},  // R6 youngest of two
    '{1'b1, 1'b0, 32'h30, 32'hA000_000C},  // R7 bypass with 3 queued
    '{1'b1, 1'b1, 32'h20, 32'h2222_0002},  // R5
    '{1'b0, 1'b0, 32'h34, 32'h4444_0004},  // fills the queue
    '{1'b1, 1'b1, 32'h34, 32'h4444_0004}   // R5 at full
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_store(input logic [31:0] a, input logic [31:0] d, output int stall);
    stall = 0;
    st_valid = 1'b1; st_addr = a; st_data = d;
    while (!st_ready && stall < 100) begin
      @(negedge clk);
      stall++;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [31:0] d, output logic fb, output int ok);
    ok = 0;
    for (int t = 0; t < 100; t++) begin
      if (rsp_valid) begin
        d = rsp_data; fb = rsp_from_buf; ok = 1;
        break;
      end
      @(negedge clk);
    end
    if (ok == 0) begin d = 'x; fb = 1'bx; end
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic fb, output int ok);
    rd_valid = 1'b1; rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    wait_rsp(d, fb, ok);
  endtask

  task automatic drain_all();
    drain_allow = 1'b1;
    for (int t = 0; t < 100 && !buf_empty; t++) @(negedge clk);
    drain_allow = 1'b0;
  endtask

  initial begin
    int stall, ok, w0, r0, extra;
    logic [31:0] d;
    logic fb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 st_ready", 32'(st_ready), 32'd1);
    chk("R9 buf_empty", 32'(buf_empty), 32'd1);
    chk("R9 buf_full", 32'(buf_full), 32'd0);
    chk("R9 mem_valid", 32'(mem_valid), 32'd0);
    chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);

    // table phase: forwarding mode, writes held back
    for (int v = 0; v < 9; v++) begin
      if (!VEC[v].is_rd) begin
        do_store(VEC[v].addr, VEC[v].data, stall);
        chk("R1 no stall", 32'(stall), 32'd0);
      end else begin
        r0 = rcount;
        do_read(VEC[v].addr, d, fb, ok);
        chk(VEC[v].exp_buf ? "R5 R6 data" : "R7 data", d, VEC[v].data);
        chk("R5 R7 source", 32'(fb), 32'(VEC[v].exp_buf));
        chk("R5 R7 memory reads", 32'(rcount - r0), VEC[v].exp_buf ? 32'd0 : 32'd1);
      end
    end
    chk("R7 no write before bypass", 32'(wcount), 32'd0);
    // R2 full
    chk("R2 buf_full", 32'(buf_full), 32'd1);
    chk("R2 st_ready low", 32'(st_ready), 32'd0);

    // R4 in-order drain
    drain_all();
    chk("R2 empty after drain", 32'(buf_empty), 32'd1);
    chk("R4 write count", 32'(wcount), 32'd4);
    chk("R4 order 0", wlog_a[0], 32'h10); chk("R4 data 0", wlog_d[0], 32'h1111_0001);
    chk("R4 order 1", wlog_a[1], 32'h20); chk("R4 data 1", wlog_d[1], 32'h2222_0002);
    chk("R4 order 2", wlog_a[2], 32'h10); chk("R4 data 2", wlog_d[2], 32'h3333_0003);
    chk("R4 order 3", wlog_a[3], 32'h34); chk("R4 data 3", wlog_d[3], 32'h4444_0004);
    do_read(32'h10, d, fb, ok);
    chk("R4 memory holds last write", d, 32'h3333_0003);
    chk("R4 answered by memory", 32'(fb), 32'd0);

    // R7 priority: read and drain permission raised together
    do_store(32'h50, 32'h5555_0005, stall);
    do_store(32'h54, 32'h5555_0006, stall);
    w0 = wcount;
    drain_allow = 1'b1;
    do_read(32'h38, d, fb, ok);
    chk("R7 read overtakes second write", 32'(rd_pos - w0), 32'd1);
    chk("R7 bypass data", d, 32'hA000_000E);
    drain_all();
    chk("R7 both writes done", 32'(wcount - w0), 32'd2);

    // R3 simultaneous store and drain
    do_store(32'h60, 32'h6, stall);
    do_store(32'h64, 32'h7, stall);
    do_store(32'h68, 32'h8, stall);
    drain_allow = 1'b1;
    st_valid = 1'b1; st_addr = 32'h6C; st_data = 32'h9;
    @(negedge clk);
    drain_allow = 1'b0;
    extra = 0;
    st_addr = 32'h70; st_data = 32'hA;
    for (int t = 0; t < 6; t++) begin
      if (st_ready) extra++;
      @(negedge clk);
    end
    st_valid = 1'b0;
    chk("R3 room left after push+pop", 32'(extra), 32'd1);
    chk("R2 full after refill", 32'(buf_full), 32'd1);
    drain_all();

    // R8 wait-for-empty mode
    cfg_wait_empty = 1'b1;
    do_store(32'h40, 32'h7777_0007, stall);
    r0 = rcount;
    rd_valid = 1'b1; rd_addr = 32'h40;
    @(negedge clk);
    rd_valid = 1'b0;
    extra = 0;
    for (int t = 0; t < 10; t++) begin
      if (rsp_valid) extra++;
      @(negedge clk);
    end
    chk("R8 no answer while held", 32'(extra), 32'd0);
    chk("R8 no memory read while held", 32'(rcount - r0), 32'd0);
    w0 = wcount;
    drain_allow = 1'b1;
    wait_rsp(d, fb, ok);
    drain_allow = 1'b0;
    chk("R8 answer arrives", 32'(ok), 32'd1);
    chk("R8 data from memory", d, 32'h7777_0007);
    chk("R8 source memory", 32'(fb), 32'd0);
    chk("R8 read after drain", 32'(rd_pos), 32'(w0 + 1));
    @(negedge clk);
    chk("R10 single pulse", 32'(rsp_valid), 32'd0);
    cfg_wait_empty = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule